// File: doc/BRIEF.md
# Strap-Addressed I2C Configuration Register

This block is a one-byte I2C target that holds the configuration of a supply controller. It takes the bus clock and data lines as plain inputs and samples them on a fast system clock. It pulls the data line low through an open-drain enable output. The 7-bit bus address is fixed except for its least significant bit, which comes from a strap input. A master writes the byte to set six control bits, which the block drives out as a bus. A master reads the byte to get those six bits back, together with two live fault flags in the low positions.

A power-good input gates the whole interface. While it is low, the block ignores all bus traffic and holds every control bit cleared, so everything it controls stays off. When it goes high, the register can be written. Once a read has started, every acknowledge from the master makes the block send a fresh copy of the byte, and a not-acknowledge ends the read.

Top module: `i2c_cfg_reg`

## Requirements
- R1: The block answers the 7-bit address 0001000 when `addr_sel` is 0 and 0001001 when `addr_sel` is 1. It acknowledges a matching address by pulling SDA low during the ninth clock. The address is sent MSB first and is followed by an R/W bit, where 1 means read.
- R2: The block does not acknowledge a non-matching address. It ignores the rest of that transfer, including later bytes, until the next START.
- R3: On a write, the block acknowledges every data byte. On that byte's acknowledge clock it loads received bits 7..2 into `ctl_q[5:0]`, with bit 7 going to `ctl_q[5]`. Received bits 1..0 are discarded.
- R4: A read returns the byte {`ctl_q[5:0]`, `flag_ot`, `flag_ol`}, MSB first, over eight clocks. The flags are sampled at the moment the byte is loaded for sending.
- R5: On the ninth clock of a read byte, a master ACK (SDA low) makes the block send another freshly sampled copy. A NACK ends the read, and SDA stays released afterwards.
- R6: While `pwr_ok` is 0, `ctl_q` is all zeros and the block never pulls SDA low, including when its own address is on the bus.
- R7: `sda_oe` changes only while SCL is low.
- R8: A STOP (SDA rising while SCL is high) or a START (SDA falling while SCL is high) aborts any transfer in progress without changing `ctl_q`. A repeated START is handled like a fresh one.
- R9: After reset, `ctl_q` is zero and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply valid; low holds the interface inert and the register cleared |
| addr_sel | input | 1 | Strap that selects the address LSB |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| flag_ot | input | 1 | Live over-temperature status |
| flag_ol | input | 1 | Live overload status |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| ctl_q | output | 6 | Control bits, MSB first as stored |

## Verification
A corrupted bit counter or state shows up on the ninth clock of the same byte. The acknowledge either goes missing or appears one bit early, so SDA is held low during a data bit. A wrong shift or load position shows up in the first byte read back after a write. The error appears as a bit pattern shifted by one place, or as the flags landing in the control bits. A missed abort on STOP or START, or a missed power-good clear, shows up at `ctl_q` within a few system clocks of that event.

// File: rtl/i2c_cfg_reg.sv
module i2c_cfg_reg #(
  parameter logic [5:0] ADDR_HI = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       flag_ot,
  input  logic       flag_ol,
  output logic       sda_oe,
  output logic [5:0] ctl_q
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       rw;

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];

  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire [7:0] rd_byte = {ctl_q, flag_ot, flag_ol};
  wire addr_hit = (sh[6:0] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 3'b111;
      sda_q  <= 3'b111;
      st     <= S_IDLE;
      sh     <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      ctl_q  <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (!pwr_ok) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        ctl_q  <= '0;
      end else if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_fall) begin
        case (st)
          S_AACK, S_WACK: sda_oe <= 1'b1;
          S_RDAT:         sda_oe <= ~sh[7];
          default:        sda_oe <= 1'b0;
        endcase
      end else if (scl_rise) begin
        case (st)
          S_ADDR: begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              rw <= sda_s;
              st <= addr_hit ? S_AACK : S_IDLE;
            end
          end
          S_AACK: begin
            cnt <= '0;
            if (rw) begin
              st <= S_RDAT;
              sh <= rd_byte;
            end else begin
              st <= S_WDAT;
            end
          end
          S_WDAT: begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= S_WACK;
          end
          S_WACK: begin
            ctl_q <= sh[7:2];
            st    <= S_WDAT;
            cnt   <= '0;
          end
          S_RDAT: begin
            sh  <= {sh[6:0], 1'b0};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= S_RACK;
          end
          S_RACK: begin
            if (!sda_s) begin
              st  <= S_RDAT;
              sh  <= rd_byte;
              cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R6: no power, no register and no drive
  assert_inert_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (ctl_q == 6'd0) && !sda_oe);

  // R7: the data line moves only in the SCL low phase
  assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && $past(pwr_ok) && !$stable(sda_oe)) |-> !$past(scl_s));

  // R3: the register changes only on a write acknowledge or a power loss
  assert_ctl_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q) |-> ($past(st) == S_WACK) || !$past(pwr_ok));

  // R2: an idle target never drives the line
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

endmodule

// File: tb/test_i2c_cfg_reg.sv
`timescale 1ns/1ps
module test_i2c_cfg_reg;
  localparam time TQ = 200ns;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0, addr_sel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, flag_ot = 1'b0, flag_ol = 1'b0;
  logic sda_oe;
  logic [5:0] ctl_q;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, r7_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string tag_q[$];

  i2c_cfg_reg i_i2c_cfg_reg (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_line), .flag_ot(flag_ot), .flag_ol(flag_ol),
    .sda_oe(sda_oe), .ctl_q(ctl_q));

  always #10ns clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g === e, t, g, e);
    end
  end

  // R7 monitor
  always @(sda_oe) if (rst_n && pwr_ok && scl_m) r7_bad++;

  task automatic bus_start();
    #TQ sda_m = 1'b1; #TQ scl_m = 1'b1; #TQ sda_m = 1'b0; #TQ scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #TQ sda_m = 1'b0; #TQ scl_m = 1'b1; #TQ sda_m = 1'b1; #TQ;
  endtask

  task automatic put_bit(input logic b);
    #TQ sda_m = b; #TQ scl_m = 1'b1; #(2*TQ) scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    #TQ sda_m = 1'b1; #TQ scl_m = 1'b1; #TQ ack = ~sda_line; #TQ scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic [7:0] exp, input string req, input bit m_ack);
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      #TQ sda_m = 1'b1; #TQ scl_m = 1'b1; #TQ b[i] = sda_line; #TQ scl_m = 1'b0;
    end
    got_q.push_back(b);
    put_bit(~m_ack);
  endtask

  logic [5:0] model;
  bit ack;

  initial begin
    #(200000 * 20ns);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model = 6'd0;
    #95ns;
    check(ctl_q == 6'd0 && sda_oe == 1'b0, "R9 reset state", {sda_oe, 1'b0, ctl_q}, 8'h00);
    rst_n = 1'b1;
    #200ns;
    // unpowered: no ack, no write
    bus_start(); send_byte(8'h10, ack);
    check(!ack, "R6 no ack unpowered", {7'd0, ack}, 8'h00);
    send_byte(8'hFC, ack); bus_stop();
    check(ctl_q == 6'd0, "R6 register held clear", {2'b0, ctl_q}, 8'h00);
    pwr_ok = 1'b1; #400ns;
    // write with strap low
    bus_start(); send_byte(8'h10, ack);
    check(ack, "R1 address 0001000 acked", {7'd0, ack}, 8'h01);
    send_byte(8'hA7, ack); model = 8'hA7 >> 2;
    check(ack, "R3 data byte acked", {7'd0, ack}, 8'h01);
    bus_stop(); #100ns;
    check(ctl_q == model, "R3 bits 7..2 loaded", {2'b0, ctl_q}, {2'b0, model});
    // read with repeated bytes
    flag_ot = 1'b1; flag_ol = 1'b0;
    bus_start(); send_byte(8'h11, ack);
    check(ack, "R4 read address acked", {7'd0, ack}, 8'h01);
    flag_ot = 1'b0; flag_ol = 1'b1;
    recv_byte({model, 2'b10}, "R4 read byte", 1'b1);
    recv_byte({model, 2'b01}, "R5 second byte after ack", 1'b0);
    #TQ;
    check(!sda_oe, "R5 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    // wrong address
    bus_start(); send_byte(8'h12, ack);
    check(!ack, "R2 mismatched address not acked", {7'd0, ack}, 8'h00);
    send_byte(8'h00, ack);
    check(!ack && ctl_q == model, "R2 later byte ignored", {ack, 1'b0, ctl_q}, {2'b0, model});
    bus_stop();
    // strap high
    addr_sel = 1'b1;
    bus_start(); send_byte(8'h10, ack);
    check(!ack, "R1 old address refused with strap high", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start(); send_byte(8'h12, ack);
    check(ack, "R1 address 0001001 acked", {7'd0, ack}, 8'h01);
    send_byte(8'hFC, ack); model = 6'h3F; #100ns;
    check(ctl_q == model, "R3 first of two bytes", {2'b0, ctl_q}, {2'b0, model});
    send_byte(8'h5F, ack); model = 8'h5F >> 2;
    bus_stop(); #100ns;
    check(ctl_q == model, "R3 second byte, low bits dropped", {2'b0, ctl_q}, {2'b0, model});
    // abort by stop mid byte
    bus_start(); send_byte(8'h12, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop(); #100ns;
    check(ctl_q == model, "R8 stop aborts write", {2'b0, ctl_q}, {2'b0, model});
    // abort by repeated start, then read
    bus_start(); send_byte(8'h12, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start(); send_byte(8'h13, ack);
    check(ack && ctl_q == model, "R8 repeated start accepted", {ack, 1'b0, ctl_q}, {1'b1, 1'b0, model});
    recv_byte({model, 2'b01}, "R8 read after repeated start", 1'b0);
    bus_stop();
    // power loss
    #200ns pwr_ok = 1'b0; #200ns;
    check(ctl_q == 6'd0, "R6 cleared on power loss", {2'b0, ctl_q}, 8'h00);
    checks++;
    if (r7_bad != 0) begin
      errors++;
      $display("FAIL R7 sda_oe changed with SCL high actual=%0d expected=0", r7_bad);
    end
    #1us;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule